// File: doc/BRIEF.md
# Cursor Register Arming Bank

This block holds the programming registers of a hardware cursor plane as two copies. Software writes a pending copy through a single-cycle write strobe that carries an address and data. The display pipeline only ever sees the active copy. Pending values move into the active copy all at once, and only at a frame-start strobe after software has armed the update. This way a cursor never shows a half-programmed mix of shape, address and position.

The base-address register is the arming register. Writing it arms the transfer of all four registers. Any later write to another register cancels the arm until the base register is written again. There is one exception: when the active cursor is disabled, a control write that selects a nonzero mode arms the update by itself.

The block also decodes the active copy into values the display side uses:
- whether the cursor is enabled;
- its width and its height in lines;
- its signed screen coordinates.

A readback port returns the pending copy, and one status address reports the arm flag.

Top module: `cursor_arm_bank`

## Requirements
- R1: After reset, all four active registers read zero, the cursor is disabled, and the arm flag is clear.
- R2: Register addresses are 0 control, 1 position, 2 base, 3 height control. A write to any of these lands in the pending copy, and the readback port shows it from the next cycle on. Address 4 reads the arm flag in bit 0. A write to any other address changes no register and leaves the arm flag as it was. Unused read addresses return zero.
- R3: A write to the base register sets the arm flag on the next cycle.
- R4: A frame-start strobe while armed loads all four active registers from the pending copy at the same edge and clears the arm flag.
- R5: Active registers change only on a frame-start strobe while armed. A frame-start strobe while not armed changes nothing.
- R6: A write to position or height control cancels a pending arm. A position-only write followed by a frame start never reaches the active copy.
- R7: A control write with a nonzero mode field (bits 1:0) arms the update when the active cursor is disabled (active mode field zero). Any other control write cancels the arm.
- R8: When a write and a frame-start strobe share a cycle, the frame start first commits the previously armed values. The write then goes to the pending copy and sets the arm flag by R3, R6 and R7, judged against the just-committed active control value.
- R9: Active mode 1, 2 and 3 give widths of 64, 128 and 256 pixels. Mode 0 means the cursor is disabled, with width and height both zero.
- R10: When bit 31 of active height control is set, the height is bits 8:0 plus one. Otherwise the height equals the width.
- R11: Position holds X in bits 15:0 and Y in bits 31:16. Each is sign-magnitude, with the sign in the top bit of its half. The decoded coordinates are the signed values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Single-cycle write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| frame_start | input | 1 | Frame boundary strobe |
| rd_addr | input | ADDR_W | Readback address |
| rd_data | output | DATA_W | Pending value or status for rd_addr |
| act_ctrl | output | DATA_W | Active control register |
| act_pos | output | DATA_W | Active position register |
| act_base | output | DATA_W | Active base-address register |
| act_hctl | output | DATA_W | Active height-control register |
| armed | output | 1 | Update armed, waiting for frame start |
| cur_enable | output | 1 | Active mode is nonzero |
| cur_width | output | HEIGHT_W+1 | Decoded cursor width |
| cur_height | output | HEIGHT_W+1 | Decoded cursor height |
| cur_x | output | COORD_W | Signed X coordinate |
| cur_y | output | COORD_W | Signed Y coordinate |

## Verification
The bench targets these corner cases:
- A position write after the arming base write. A design that ignored the cancel would let the cursor move while the old base still stood.
- A frame start in the same cycle as a write. A design with the wrong order would either commit the new write too early or lose the commit.
- The enabling control write that lands in the same cycle as a frame start disabling the cursor. This must still arm, because the disabled test has to see the freshly committed value.
- The height override, mode-zero decoding and negative sign-magnitude coordinates. Each of these is checked against an independent behavioural model on every clock.

// File: rtl/cursor_bank_pkg.sv
package cursor_bank_pkg;
   localparam int NUM_REGS    = 4;
   localparam int REG_IDX_W   = 2;
   localparam int STATUS_ADDR = 4;

   typedef enum logic [REG_IDX_W-1:0] {
      REG_CTRL = 2'd0,
      REG_POS  = 2'd1,
      REG_BASE = 2'd2,
      REG_HCTL = 2'd3
   } cursor_reg_e;
endpackage

// File: rtl/cursor_shadow_pair.sv
module cursor_shadow_pair #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] din,
   input  logic         commit,
   output logic [W-1:0] pend,
   output logic [W-1:0] act
);
   // pending copy: software side
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend <= '0;
      else if (load) pend <= din;
   end

   // active copy: takes the pending value seen before this edge's write
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) act <= '0;
      else if (commit) act <= pend;
   end

   a_r2_pending_write: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> pend == $past(din));
   a_r4_commit_loads: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> act == $past(pend));
   a_r5_hold_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> act == $past(act));
endmodule

// File: rtl/cursor_arm_ctrl.sv
module cursor_arm_ctrl
   import cursor_bank_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_valid,
   input  logic [REG_IDX_W-1:0] wr_idx,
   input  logic                 wr_mode_nz,
   input  logic                 live_mode_nz,
   input  logic                 frame_start,
   output logic                 armed,
   output logic                 commit
);
   logic armed_d;

   assign commit = frame_start & armed;

   // commit clears the flag first; a write in the same cycle decides afterwards
   always_comb begin
      armed_d = armed & ~commit;
      if (wr_valid) begin
         unique case (wr_idx)
            REG_BASE: armed_d = 1'b1;
            REG_CTRL: armed_d = wr_mode_nz & ~live_mode_nz;
            default:  armed_d = 1'b0;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed <= 1'b0;
      else armed <= armed_d;
   end

   a_r3_base_arms: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid && wr_idx == REG_BASE |=> armed);
   a_r6_write_cancels: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid && (wr_idx == REG_POS || wr_idx == REG_HCTL) |=> !armed);
   a_r4_commit_clears: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start && armed && !wr_valid |=> !armed);
   a_r7_enable_arms: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid && wr_idx == REG_CTRL && wr_mode_nz && !live_mode_nz |=> armed);
   a_r5_idle_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_valid && !frame_start |=> armed == $past(armed));
endmodule

// File: rtl/cursor_geom_decode.sv
module cursor_geom_decode #(
   parameter int DATA_W    = 32,
   parameter int MODE_W    = 2,
   parameter int HEIGHT_W  = 9,
   parameter int MIN_WIDTH = 64,
   parameter int COORD_W   = 16
) (
   input  logic [DATA_W-1:0]             ctrl,
   input  logic [DATA_W-1:0]             hctl,
   input  logic [DATA_W-1:0]             pos,
   output logic                          enable,
   output logic [HEIGHT_W:0]             width,
   output logic [HEIGHT_W:0]             height,
   output logic [1:0][COORD_W-1:0]       coord
);
   localparam int DIM_W      = HEIGHT_W + 1;
   localparam int HCTL_EN_BIT = DATA_W - 1;

   logic [MODE_W-1:0] mode;
   assign mode   = ctrl[MODE_W-1:0];
   assign enable = |mode;

   always_comb begin
      width = '0;
      if (enable) width = DIM_W'(MIN_WIDTH) << (mode - MODE_W'(1));
   end

   always_comb begin
      height = '0;
      if (enable) begin
         if (hctl[HCTL_EN_BIT]) height = DIM_W'(hctl[HEIGHT_W-1:0]) + DIM_W'(1);
         else height = width;
      end
   end

   // one sign-magnitude decoder per axis: 0 = X, 1 = Y
   for (genvar a = 0; a < 2; a++) begin : g_axis
      logic [COORD_W-1:0] field;
      logic [COORD_W-1:0] mag;
      assign field = pos[a*COORD_W +: COORD_W];
      assign mag   = {1'b0, field[COORD_W-2:0]};
      assign coord[a] = field[COORD_W-1] ? (~mag + COORD_W'(1)) : mag;
   end
endmodule

// File: rtl/cursor_arm_bank.sv
module cursor_arm_bank
   import cursor_bank_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int ADDR_W    = 3,
   parameter int MODE_W    = 2,
   parameter int HEIGHT_W  = 9,
   parameter int MIN_WIDTH = 64,
   parameter int COORD_W   = 16
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic [ADDR_W-1:0]         wr_addr,
   input  logic [DATA_W-1:0]         wr_data,
   input  logic                      frame_start,
   input  logic [ADDR_W-1:0]         rd_addr,
   output logic [DATA_W-1:0]         rd_data,
   output logic [DATA_W-1:0]         act_ctrl,
   output logic [DATA_W-1:0]         act_pos,
   output logic [DATA_W-1:0]         act_base,
   output logic [DATA_W-1:0]         act_hctl,
   output logic                      armed,
   output logic                      cur_enable,
   output logic [HEIGHT_W:0]         cur_width,
   output logic [HEIGHT_W:0]         cur_height,
   output logic signed [COORD_W-1:0] cur_x,
   output logic signed [COORD_W-1:0] cur_y
);
   localparam int MAX_WIDTH = MIN_WIDTH << ((1 << MODE_W) - 2);
   localparam int DIM_W     = HEIGHT_W + 1;

   if (2 * COORD_W > DATA_W) begin : g_bad_coord
      $error("position fields do not fit in DATA_W");
   end
   if (HEIGHT_W + 1 >= DATA_W || MODE_W >= DATA_W) begin : g_bad_fields
      $error("field widths do not fit in DATA_W");
   end
   if (MAX_WIDTH >= (1 << DIM_W)) begin : g_bad_dim
      $error("largest width does not fit the dimension outputs");
   end
   if ((1 << ADDR_W) <= STATUS_ADDR) begin : g_bad_addr
      $error("ADDR_W too small for the status address");
   end

   logic                            wr_is_reg;
   logic [REG_IDX_W-1:0]            wr_idx;
   logic [NUM_REGS-1:0][DATA_W-1:0] pend_q;
   logic [NUM_REGS-1:0][DATA_W-1:0] act_q;
   logic                            commit;
   logic [MODE_W-1:0]               live_mode;
   logic [1:0][COORD_W-1:0]         coord;

   assign wr_is_reg = wr_en && (wr_addr < ADDR_W'(NUM_REGS));
   assign wr_idx    = wr_addr[REG_IDX_W-1:0];

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      cursor_shadow_pair #(.W(DATA_W)) u_pair (
         .clk    (clk),
         .rst_n  (rst_n),
         .load   (wr_is_reg && wr_idx == REG_IDX_W'(i)),
         .din    (wr_data),
         .commit (commit),
         .pend   (pend_q[i]),
         .act    (act_q[i])
      );
   end

   // mode the active copy holds once this edge's commit has happened
   assign live_mode = commit ? pend_q[REG_CTRL][MODE_W-1:0]
                             : act_q[REG_CTRL][MODE_W-1:0];

   cursor_arm_ctrl u_arm (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_valid     (wr_is_reg),
      .wr_idx       (wr_idx),
      .wr_mode_nz   (|wr_data[MODE_W-1:0]),
      .live_mode_nz (|live_mode),
      .frame_start  (frame_start),
      .armed        (armed),
      .commit       (commit)
   );

   always_comb begin
      rd_data = '0;
      if (rd_addr < ADDR_W'(NUM_REGS)) rd_data = pend_q[rd_addr[REG_IDX_W-1:0]];
      else if (rd_addr == ADDR_W'(STATUS_ADDR)) rd_data[0] = armed;
   end

   assign act_ctrl = act_q[REG_CTRL];
   assign act_pos  = act_q[REG_POS];
   assign act_base = act_q[REG_BASE];
   assign act_hctl = act_q[REG_HCTL];

   cursor_geom_decode #(
      .DATA_W    (DATA_W),
      .MODE_W    (MODE_W),
      .HEIGHT_W  (HEIGHT_W),
      .MIN_WIDTH (MIN_WIDTH),
      .COORD_W   (COORD_W)
   ) u_geom (
      .ctrl   (act_q[REG_CTRL]),
      .hctl   (act_q[REG_HCTL]),
      .pos    (act_q[REG_POS]),
      .enable (cur_enable),
      .width  (cur_width),
      .height (cur_height),
      .coord  (coord)
   );

   assign cur_x = coord[0];
   assign cur_y = coord[1];

   a_r8_same_cycle_commit: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start && armed && wr_en |=> act_base == $past(pend_q[REG_BASE]));
   a_r9_disabled_zero: assert property (@(posedge clk) disable iff (!rst_n)
      act_ctrl[MODE_W-1:0] == '0 |-> cur_width == '0 && cur_height == '0);
endmodule

// File: tb/cursor_arm_bank_test.sv
module cursor_arm_bank_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic        frame_start = 1'b0;
   logic [2:0]  rd_addr = '0;
   logic [31:0] rd_data, act_ctrl, act_pos, act_base, act_hctl;
   logic        armed, cur_enable;
   logic [9:0]  cur_width, cur_height;
   logic signed [15:0] cur_x, cur_y;

   int checks = 0;
   int errors = 0;

   logic [31:0] m_pend [4];
   logic [31:0] m_act  [4];
   bit          m_armed;

   always #2 clk = ~clk;

   cursor_arm_bank uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .frame_start(frame_start), .rd_addr(rd_addr),
      .rd_data(rd_data), .act_ctrl(act_ctrl), .act_pos(act_pos),
      .act_base(act_base), .act_hctl(act_hctl), .armed(armed),
      .cur_enable(cur_enable), .cur_width(cur_width), .cur_height(cur_height),
      .cur_x(cur_x), .cur_y(cur_y)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_width(input logic [31:0] ctrl);
      if (ctrl[1:0] == 2'd0) return 32'd0;
      return 32'd64 << (ctrl[1:0] - 1);
   endfunction

   function automatic logic [31:0] exp_height(input logic [31:0] ctrl, input logic [31:0] hctl);
      if (ctrl[1:0] == 2'd0) return 32'd0;
      if (hctl[31]) return {23'd0, hctl[8:0]} + 32'd1;
      return exp_width(ctrl);
   endfunction

   function automatic logic [15:0] exp_coord(input logic [15:0] f);
      int v;
      v = f[15] ? -int'(f[14:0]) : int'(f[14:0]);
      return 16'(v);
   endfunction

   // behavioural reference of one clock edge (R4, R5, R3, R6, R7, R8)
   task automatic model_step(input bit wr, input logic [2:0] a, input logic [31:0] d, input bit fs);
      if (fs && m_armed) begin
         for (int k = 0; k < 4; k++) m_act[k] = m_pend[k];
         m_armed = 1'b0;
      end
      if (wr && a < 3'd4) begin
         m_pend[a] = d;
         if (a == 3'd2) m_armed = 1'b1;
         else if (a == 3'd0) m_armed = (m_act[0][1:0] == 2'd0) && (d[1:0] != 2'd0);
         else m_armed = 1'b0;
      end
   endtask

   task automatic compare_all();
      logic [31:0] rd_exp;
      if (rd_addr < 3'd4) rd_exp = m_pend[rd_addr];
      else if (rd_addr == 3'd4) rd_exp = {31'd0, m_armed};
      else rd_exp = 32'd0;
      chk("R4 model act_ctrl", act_ctrl, m_act[0]);
      chk("R4 model act_pos",  act_pos,  m_act[1]);
      chk("R4 model act_base", act_base, m_act[2]);
      chk("R4 model act_hctl", act_hctl, m_act[3]);
      chk("R3 model armed", {31'd0, armed}, {31'd0, m_armed});
      chk("R2 model rd_data", rd_data, rd_exp);
      chk("R9 model enable", {31'd0, cur_enable}, {31'd0, m_act[0][1:0] != 2'd0});
      chk("R9 model width", {22'd0, cur_width}, exp_width(m_act[0]));
      chk("R10 model height", {22'd0, cur_height}, exp_height(m_act[0], m_act[3]));
      chk("R11 model x", {16'd0, cur_x}, {16'd0, exp_coord(m_act[1][15:0])});
      chk("R11 model y", {16'd0, cur_y}, {16'd0, exp_coord(m_act[1][31:16])});
   endtask

   task automatic cyc(input bit wr, input logic [2:0] a, input logic [31:0] d,
                      input bit fs, input logic [2:0] ra);
      @(negedge clk);
      wr_en = wr; wr_addr = a; wr_data = d; frame_start = fs; rd_addr = ra;
      @(posedge clk);
      model_step(wr, a, d, fs);
      #1;
      compare_all();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      for (int k = 0; k < 4; k++) begin m_pend[k] = '0; m_act[k] = '0; end
      m_armed = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: reset state
      chk("R1 act_ctrl", act_ctrl, 0);
      chk("R1 act_base", act_base, 0);
      chk("R1 armed", {31'd0, armed}, 0);
      chk("R1 enable", {31'd0, cur_enable}, 0);
      rst_n = 1'b1;

      // R7: enabling control write arms while disabled
      cyc(1, 3'd0, 32'h1, 0, 3'd0);
      chk("R7 enable arms", {31'd0, armed}, 1);
      chk("R5 active unchanged", act_ctrl, 0);
      cyc(0, 3'd0, 0, 1, 3'd0);
      chk("R4 ctrl committed", act_ctrl, 32'h1);
      chk("R4 armed cleared", {31'd0, armed}, 0);
      chk("R9 width 64", {22'd0, cur_width}, 64);

      // R6: position write alone never lands
      cyc(1, 3'd1, 32'h000A_8005, 0, 3'd1);
      chk("R2 pending readback", rd_data, 32'h000A_8005);
      cyc(0, 3'd0, 0, 1, 3'd4);
      chk("R6 pos alone ignored", act_pos, 0);

      // R3 then R4 with R11 decode
      cyc(1, 3'd2, 32'h1000, 0, 3'd4);
      chk("R3 base arms", {31'd0, armed}, 1);
      chk("R2 status bit", rd_data, 1);
      cyc(0, 3'd0, 0, 1, 3'd0);
      chk("R4 pos committed", act_pos, 32'h000A_8005);
      chk("R4 base committed", act_base, 32'h1000);
      chk("R11 x negative", {16'd0, cur_x}, 32'h0000_FFFB);
      chk("R11 y positive", {16'd0, cur_y}, 32'd10);

      // R6: later write cancels arm
      cyc(1, 3'd2, 32'h2000, 0, 3'd0);
      cyc(1, 3'd1, 32'h0003_0003, 0, 3'd0);
      chk("R6 cancel", {31'd0, armed}, 0);
      cyc(0, 3'd0, 0, 1, 3'd0);
      chk("R6 base kept", act_base, 32'h1000);

      // R10 height override
      cyc(1, 3'd3, 32'h8000_001F, 0, 3'd0);
      cyc(1, 3'd2, 32'h3000, 0, 3'd0);
      cyc(0, 3'd0, 0, 1, 3'd0);
      chk("R10 height 32", {22'd0, cur_height}, 32);
      chk("R10 width 64", {22'd0, cur_width}, 64);

      // R7 non-enabling control write does not arm
      cyc(1, 3'd0, 32'h2, 0, 3'd0);
      chk("R7 no arm while enabled", {31'd0, armed}, 0);
      cyc(1, 3'd3, 32'h0, 0, 3'd0);
      cyc(1, 3'd2, 32'h4000, 0, 3'd0);
      cyc(0, 3'd0, 0, 1, 3'd0);
      chk("R9 width 128", {22'd0, cur_width}, 128);
      chk("R10 square height", {22'd0, cur_height}, 128);

      // R8 same-cycle write and frame start
      cyc(1, 3'd2, 32'h5000, 0, 3'd0);
      cyc(1, 3'd1, 32'h7, 1, 3'd1);
      chk("R8 old values commit", act_base, 32'h5000);
      chk("R8 old pos commits", act_pos, 32'h0003_0003);
      chk("R8 write lands pending", rd_data, 32'h7);
      chk("R8 arm after pos", {31'd0, armed}, 0);
      cyc(1, 3'd2, 32'h6000, 1, 3'd0);
      chk("R8 no commit unarmed", act_base, 32'h5000);
      chk("R8 base arms same cycle", {31'd0, armed}, 1);

      // R8 + R7: enabling write sees freshly committed disable
      cyc(1, 3'd0, 32'h0, 0, 3'd0);
      cyc(1, 3'd2, 32'h6000, 0, 3'd0);
      cyc(1, 3'd0, 32'h3, 1, 3'd0);
      chk("R8 disable committed", act_ctrl, 0);
      chk("R9 disabled width", {22'd0, cur_width}, 0);
      chk("R7 enable arms after commit", {31'd0, armed}, 1);
      cyc(0, 3'd0, 0, 1, 3'd0);
      chk("R9 width 256", {22'd0, cur_width}, 256);

      // R2 unused address ignored
      cyc(1, 3'd2, 32'h7000, 0, 3'd0);
      cyc(1, 3'd5, 32'hFFFF_FFFF, 0, 3'd5);
      chk("R2 unused addr no cancel", {31'd0, armed}, 1);
      chk("R2 unused addr reads 0", rd_data, 0);
      cyc(0, 3'd0, 0, 0, 3'd4);
      chk("R2 status armed", rd_data, 1);

      // mixed traffic against the model
      for (int i = 0; i < 600; i++) begin
         logic [31:0] d;
         d = $urandom;
         cyc(($urandom % 3) != 0, 3'($urandom % 6), d, ($urandom % 4) == 0, 3'($urandom % 8));
      end
      cyc(0, 3'd0, 0, 0, 3'd0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule